// File: doc/BRIEF.md
# Dead-Time and Gate Interval Timer

This block is one 16-bit interval timer channel with two uses. In dead-time mode it follows a single PWM input and drives a complementary pair of outputs. After every change of the PWM level, both outputs go low for a programmed non-overlap interval. Once that interval ends, only the output that matches the new level goes high. In gate mode a start trigger raises a single gate output for a programmed number of ticks. That gate is meant to enable a companion PWM generator.

The interval length comes from one compare register written through a simple word-addressed write port, where each byte lane has its own enable. A prescale tick input supplies the timebase, and every count advances only on that tick. The compare value is copied into the down-counter only when an interval starts, so a write during a running interval takes effect at the next start. The produced length is the compare value plus one tick. A written value of zero is replaced by one, and a sticky-until-rewritten flag reports it.

Top module: `dgt_timer`

## Requirements
- R1: After reset, `rd_data` reads 0x0001, `zero_err` is 0, and `drv_hi`, `drv_lo` and `gate_out` are all low.
- R2: A write with `wr_en` high and `wr_addr` equal to `REG_ADDR` updates bits 7..0 when `wr_be[0]` is set and bits 15..8 when `wr_be[1]` is set. Lanes without an enable, and writes to any other address, leave the value unchanged. `rd_data` shows the stored 16-bit value one clock after the write.
- R3: A write whose merged 16-bit result is 0x0000 stores 0x0001 and sets `zero_err`. A write whose merged result is nonzero stores that value and clears `zero_err`.
- R4: In dead-time mode (`mode` = 0), a rising or falling edge of `pwm_in` forces both `drv_hi` and `drv_lo` low on the next clock. On the (N+1)-th tick after the edge, where N is the latched compare value, `drv_hi` goes high if `pwm_in` is 1, or `drv_lo` goes high if `pwm_in` is 0.
- R5: A `pwm_in` edge arriving before the dead-time interval ends restarts the interval from the current compare value. Both outputs stay low until the restarted interval ends.
- R6: The compare value is latched only when an interval starts, in either mode. A write during a running interval does not change that interval's length and applies from the next start.
- R7: In gate mode (`mode` = 1), `start` sampled high while `gate_out` is low raises `gate_out` on the next clock. `gate_out` falls on the (N+1)-th tick after that.
- R8: `start` asserted while `gate_out` is high is ignored, and the gate keeps its original end time.
- R9: In gate mode `drv_hi` and `drv_lo` stay low and `pwm_in` has no effect. In dead-time mode `gate_out` stays low and `start` has no effect. Changing `mode` ends a running gate or dead-time interval with its outputs low.
- R10: `drv_hi` and `drv_lo` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_be | input | 2 | Byte-lane enables, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Stored compare value |
| zero_err | output | 1 | Last write produced a zero value that was replaced by one |
| tick | input | 1 | Prescale timebase enable, one clock wide |
| start | input | 1 | Gate trigger, used in gate mode |
| mode | input | 1 | 0 = dead-time, 1 = gate |
| pwm_in | input | 1 | PWM input, used in dead-time mode |
| drv_hi | output | 1 | Output active while PWM is high, after dead time |
| drv_lo | output | 1 | Output active while PWM is low, after dead time |
| gate_out | output | 1 | Gate pulse for the companion PWM generator |

## Verification
The hardest situation to reach from the ports is an interval in which the compare value changes or the PWM input toggles again while the down-counter is already part way through its count. Both cases must show the outputs following the old latched length, or the restarted one, and not the register value. The bench reaches these states by issuing prescale ticks one at a time under its own control. It then places a register write or a second PWM edge between ticks at a known count. The expected expiry tick is computed from the value latched at the last start.

// File: rtl/dgt_pkg.sv
package dgt_pkg;

  localparam int CMP_W   = 16;
  localparam int LANE_W  = 8;
  localparam int LANES   = CMP_W / LANE_W;

  typedef logic [CMP_W-1:0] cmp_t;

  typedef enum logic {
    MODE_DEADTIME = 1'b0,
    MODE_GATE     = 1'b1
  } run_mode_e;

  // Merge write data into the old value lane by lane.
  function automatic cmp_t merge_lanes(cmp_t old_v, cmp_t new_v,
                                       logic [LANES-1:0] lane_en);
    cmp_t res;
    res = old_v;
    for (int i = 0; i < LANES; i++) begin
      if (lane_en[i]) res[i*LANE_W +: LANE_W] = new_v[i*LANE_W +: LANE_W];
    end
    return res;
  endfunction

  // A zero compare value is illegal: substitute the shortest legal one.
  function automatic cmp_t legalize(cmp_t v);
    return (v == '0) ? cmp_t'(1) : v;
  endfunction

endpackage

// File: rtl/dgt_cmp_reg.sv
module dgt_cmp_reg
  import dgt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_be,
  input  cmp_t              wr_data,
  output cmp_t              cmp_q,
  output logic              zero_err
);

  logic write_hit;
  cmp_t merged;
  logic merged_zero;

  assign write_hit = wr_en && (wr_addr == REG_ADDR);

  // Per-lane merge as separate wires so each lane is visible.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_wr;
    assign lane_wr = write_hit && wr_be[g];
    assign merged[g*LANE_W +: LANE_W] =
      lane_wr ? wr_data[g*LANE_W +: LANE_W] : cmp_q[g*LANE_W +: LANE_W];
  end

  assign merged_zero = (merged == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q    <= cmp_t'(1);
      zero_err <= 1'b0;
    end else if (write_hit) begin
      cmp_q    <= legalize(merged);
      zero_err <= merged_zero;
    end
  end

  AST_CMP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_q != '0);                                             // R3
  AST_ZERO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    write_hit && merged_zero |=> cmp_q == cmp_t'(1) && zero_err); // R3
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !write_hit |=> $stable(cmp_q));                           // R2

endmodule

// File: rtl/dgt_counter.sv
module dgt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_zero
);

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step && !at_zero) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step && at_zero && !load |=> cnt_q == '0);               // R6
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));                      // R6

endmodule

// File: rtl/dgt_dead_ctl.sv
module dgt_dead_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic pwm_in,
  input  logic tick,
  input  logic cnt_zero,
  output logic load_req,
  output logic step_req,
  output logic drv_hi,
  output logic drv_lo
);

  logic pwm_q;
  logic pwm_edge;
  logic busy_q;
  logic expire;

  // Previous input level is tracked in every mode, so a mode change
  // never manufactures an edge.
  assign pwm_edge = pwm_in ^ pwm_q;
  assign load_req = active && pwm_edge;
  assign step_req = active && busy_q && tick;
  assign expire   = active && busy_q && tick && cnt_zero && !pwm_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_q  <= 1'b0;
      busy_q <= 1'b0;
      drv_hi <= 1'b0;
      drv_lo <= 1'b0;
    end else begin
      pwm_q <= pwm_in;
      if (!active || pwm_edge) begin
        busy_q <= active && pwm_edge;
        drv_hi <= 1'b0;
        drv_lo <= 1'b0;
      end else if (expire) begin
        busy_q <= 1'b0;
        drv_hi <= pwm_q;
        drv_lo <= !pwm_q;
      end
    end
  end

  AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_hi && drv_lo));                                     // R10
  AST_EDGE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    active && pwm_edge |=> !drv_hi && !drv_lo);               // R5
  AST_DRIVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_hi) || $rose(drv_lo) |-> $past(tick));          // R4
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !drv_hi && !drv_lo);                          // R9

endmodule

// File: rtl/dgt_gate_ctl.sv
module dgt_gate_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic start,
  input  logic tick,
  input  logic cnt_zero,
  output logic load_req,
  output logic step_req,
  output logic gate_q
);

  logic fire;
  logic expire;

  assign fire     = active && start && !gate_q;
  assign load_req = fire;
  assign step_req = active && gate_q && tick;
  assign expire   = active && gate_q && tick && cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else if (!active) begin
      gate_q <= 1'b0;
    end else if (fire) begin
      gate_q <= 1'b1;
    end else if (expire) begin
      gate_q <= 1'b0;
    end
  end

  AST_GATE_FALL_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_q) |-> $past(tick) || $past(!active));         // R7
  AST_GATE_RETRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    active && gate_q && start && !(tick && cnt_zero) |=> gate_q); // R8
  AST_GATE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !gate_q);                                     // R9

endmodule

// File: rtl/dgt_timer.sv
module dgt_timer
  import dgt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_be,
  input  logic [CMP_W-1:0]  wr_data,
  output logic [CMP_W-1:0]  rd_data,
  output logic              zero_err,
  input  logic              tick,
  input  logic              start,
  input  logic              mode,
  input  logic              pwm_in,
  output logic              drv_hi,
  output logic              drv_lo,
  output logic              gate_out
);

  run_mode_e mode_e;
  logic      dead_active;
  logic      gate_active;
  cmp_t      cmp_q;
  cmp_t      cnt_q;
  logic      cnt_zero;
  logic      dead_load, dead_step;
  logic      gate_load, gate_step;
  logic      cnt_load, cnt_step;

  assign mode_e      = run_mode_e'(mode);
  assign dead_active = (mode_e == MODE_DEADTIME);
  assign gate_active = (mode_e == MODE_GATE);

  dgt_cmp_reg #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .cmp_q    (cmp_q),
    .zero_err (zero_err)
  );

  // One shared down-counter: the two controllers are never active together.
  assign cnt_load = dead_load | gate_load;
  assign cnt_step = dead_step | gate_step;

  dgt_counter #(.CNT_W(CMP_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cmp_q),
    .step     (cnt_step),
    .cnt_q    (cnt_q),
    .at_zero  (cnt_zero)
  );

  dgt_dead_ctl u_dead (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (dead_active),
    .pwm_in   (pwm_in),
    .tick     (tick),
    .cnt_zero (cnt_zero),
    .load_req (dead_load),
    .step_req (dead_step),
    .drv_hi   (drv_hi),
    .drv_lo   (drv_lo)
  );

  dgt_gate_ctl u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (gate_active),
    .start    (start),
    .tick     (tick),
    .cnt_zero (cnt_zero),
    .load_req (gate_load),
    .step_req (gate_step),
    .gate_q   (gate_out)
  );

  assign rd_data = cmp_q;

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_out && (drv_hi || drv_lo)));                       // R9
  AST_ONE_LOADER: assert property (@(posedge clk) disable iff (!rst_n)
    !(dead_load && gate_load));                               // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> cnt_q != '0);                                // R3

endmodule

// File: tb/test_dgt_timer.sv
module test_dgt_timer;

  localparam logic [3:0] A_REG = 4'h6;
  localparam logic [3:0] A_BAD = 4'h7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        zero_err;
  logic        tick = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic        pwm_in = 1'b0;
  logic        drv_hi, drv_lo, gate_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  dgt_timer i_dgt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
    .zero_err(zero_err), .tick(tick), .start(start), .mode(mode),
    .pwm_in(pwm_in), .drv_hi(drv_hi), .drv_lo(drv_lo), .gate_out(gate_out)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // outputs as {hi, lo, gate}
  function automatic logic [31:0] outs();
    return {29'd0, drv_hi, drv_lo, gate_out};
  endfunction

  task automatic reg_write(input logic [3:0] a, input logic [1:0] be,
                           input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_pwm(input logic v);
    @(negedge clk); pwm_in = v;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "reset rd_data", rd_data, 32'h1);
    check("R1", "reset zero_err", zero_err, 0);
    check("R1", "reset outputs", outs(), 0);
  endtask

  task automatic t_lanes();
    reg_write(A_REG, 2'b11, 16'h0005);
    check("R2", "full write", rd_data, 32'h0005);
    reg_write(A_REG, 2'b01, 16'hAA33);
    check("R2", "low lane only", rd_data, 32'h0033);
    reg_write(A_REG, 2'b10, 16'h1277);
    check("R2", "high lane only", rd_data, 32'h1233);
    reg_write(A_BAD, 2'b11, 16'hBEEF);
    check("R2", "other address ignored", rd_data, 32'h1233);
    reg_write(A_REG, 2'b00, 16'hBEEF);
    check("R2", "no lane enabled", rd_data, 32'h1233);
  endtask

  task automatic t_zero();
    reg_write(A_REG, 2'b11, 16'h0000);
    check("R3", "zero stored as one", rd_data, 32'h1);
    check("R3", "zero flag set", zero_err, 1);
    reg_write(A_REG, 2'b11, 16'h0033);
    check("R3", "nonzero clears flag", zero_err, 0);
    reg_write(A_REG, 2'b01, 16'h0000);
    check("R3", "byte path zero", rd_data, 32'h1);
    check("R3", "byte path flag", zero_err, 1);
    // legalised value 1 gives a 2-tick dead time (pwm currently 0)
    set_pwm(1'b1);
    ticks(1);
    check("R3", "len2 after 1 tick", outs(), 0);
    ticks(1);
    check("R3", "len2 after 2 ticks", outs(), 32'b100);
  endtask

  task automatic t_dead_basic();
    reg_write(A_REG, 2'b11, 16'd3);
    set_pwm(1'b0);
    check("R4", "fall edge blanks", outs(), 0);
    ticks(3);
    check("R4", "low pair during N ticks", outs(), 0);
    ticks(1);
    check("R4", "lo drives at N+1", outs(), 32'b010);
    set_pwm(1'b1);
    check("R4", "rise edge blanks", outs(), 0);
    ticks(3);
    check("R4", "still blank", outs(), 0);
    ticks(1);
    check("R4", "hi drives at N+1", outs(), 32'b100);
    check("R10", "pair exclusive", {31'd0, drv_hi & drv_lo}, 0);
  endtask

  task automatic t_dead_restart();
    set_pwm(1'b0);
    ticks(2);
    set_pwm(1'b1);
    check("R5", "restart blanks", outs(), 0);
    ticks(3);
    check("R5", "restarted interval still blank", outs(), 0);
    ticks(1);
    check("R5", "restarted interval ends", outs(), 32'b100);
  endtask

  task automatic t_dead_latch();
    set_pwm(1'b0);
    ticks(1);
    reg_write(A_REG, 2'b11, 16'd9);
    ticks(2);
    check("R6", "old length holds", outs(), 0);
    ticks(1);
    check("R6", "old length ends", outs(), 32'b010);
    set_pwm(1'b1);
    ticks(9);
    check("R6", "new length blank", outs(), 0);
    ticks(1);
    check("R6", "new length ends", outs(), 32'b100);
  endtask

  task automatic t_gate();
    @(negedge clk); mode = 1'b1;
    @(negedge clk);
    check("R9", "pair low in gate mode", outs(), 0);
    reg_write(A_REG, 2'b11, 16'd4);
    pulse_start();
    check("R7", "gate rises", outs(), 32'b001);
    ticks(4);
    check("R7", "gate held N ticks", outs(), 32'b001);
    ticks(1);
    check("R7", "gate falls at N+1", outs(), 0);
    pulse_start();
    ticks(2);
    pulse_start();
    check("R8", "retrigger keeps gate", outs(), 32'b001);
    ticks(2);
    check("R8", "original end pending", outs(), 32'b001);
    ticks(1);
    check("R8", "original end kept", outs(), 0);
    pulse_start();
    reg_write(A_REG, 2'b11, 16'd1);
    ticks(4);
    check("R6", "gate old length holds", outs(), 32'b001);
    ticks(1);
    check("R6", "gate old length ends", outs(), 0);
    pulse_start();
    ticks(1);
    check("R6", "gate new length mid", outs(), 32'b001);
    ticks(1);
    check("R6", "gate new length ends", outs(), 0);
  endtask

  task automatic t_isolation();
    set_pwm(~pwm_in);
    ticks(3);
    check("R9", "pwm ignored in gate mode", outs(), 0);
    pulse_start();
    check("R9", "gate up before switch", outs(), 32'b001);
    @(negedge clk); mode = 1'b0;
    @(negedge clk);
    check("R9", "mode change drops gate", outs(), 0);
    pulse_start();
    ticks(3);
    check("R9", "start ignored in dead mode", outs(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_zero();
    t_dead_basic();
    t_dead_restart();
    t_dead_latch();
    t_gate();
    t_isolation();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule